// File: doc/BRIEF.md
# Buck Output Protection Sequencer

This block decides, once per switching cycle, how one buck output reacts to its protection inputs. It receives a sampled overcurrent indication, a soft-start-complete flag and three comparator window flags: below the undervoltage trip level, above the overvoltage level, and inside the power-good band. From these it produces a pulse-terminate strobe, two gate overrides, a latched fault flag and this output's share of the power-good signal. The comparators and their thresholds sit outside the block. `clk` is the switching clock, so one clock is one switching period.

A first overcurrent only cuts the present high-side pulse short and arms a window timer. The converter is shut down only when a second overcurrent lands in a delayed window, cycles 8 to 16 after the first. That is about 26 to 53 us at a 300 kHz switching rate. If the window passes without a second event, the timer goes idle and the next overcurrent starts a fresh window. An undervoltage after soft-start also latches the converter off. An overvoltage applies a soft-crowbar that lasts only as long as the condition does. A latched fault clears only on reset or when the enable is dropped.

Top module: `fault_supervisor`

## Requirements
- R1: While `enable` is 1 and no fault is latched, `pulseEnd` equals `ocSample` in the same cycle, with no register delay. Otherwise `pulseEnd` is 0.
- R2: An overcurrent seen in cycle k while the timer is idle arms the timer. A further overcurrent in cycle k+n with 8 <= n <= 16 sets `faultLatched` to 1 from cycle k+n+1.
- R3: Overcurrents in cycles k+1 to k+7 neither latch a fault nor restart the timer. If no overcurrent falls in the window, the timer is idle again from cycle k+17. An overcurrent there starts a new window instead of latching.
- R4: `uvFlag`=1 while `ssDone`=1 and `enable`=1 sets `faultLatched` from the next cycle. `uvFlag` has no effect while `ssDone`=0.
- R5: While `ovFlag`=1, `enable`=1 and no fault is latched, `hsOff`=1 and `lsOn`=1 in the same cycle. Both return to 0 in the first cycle with `ovFlag`=0, and no fault is latched by it.
- R6: `pwrGood` is 1 exactly when `enable`, `ssDone` and `pgWindow` are all 1 and no fault is latched.
- R7: A latched fault holds `hsOff`=1, `lsOn`=0, `pulseEnd`=0 and `pwrGood`=0, whatever the inputs, as long as `enable` stays 1. A cycle with `enable`=0 forces `hsOff`=1 and `lsOn`=0, and clears the latch from the next cycle.
- R8: During and after reset with `enable`=0, `faultLatched`=0, `pulseEnd`=0, `lsOn`=0 and `hsOff`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock, one edge per switching period |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable; 0 turns the output off and clears a latched fault |
| ocSample | input | 1 | Overcurrent sample for this cycle |
| ssDone | input | 1 | Soft-start has completed |
| uvFlag | input | 1 | Output below the undervoltage trip level |
| ovFlag | input | 1 | Output above the overvoltage level |
| pgWindow | input | 1 | Output inside the power-good band |
| pulseEnd | output | 1 | Terminate the present high-side pulse |
| hsOff | output | 1 | Force the high-side gate off |
| lsOn | output | 1 | Force the low-side gate on |
| faultLatched | output | 1 | Converter is latched off |
| pwrGood | output | 1 | Power-good contribution of this output |

## Verification
Pairs of overcurrent events are placed 7, 8, 16 and 17 cycles apart. These spacings separate the early blanking span, the two window edges and the rearm point. Three-event sequences (0/3/10, 0/3/19 and 0/17/25) show whether an early second event wrongly restarts the timer, and whether a clean window really rearms it. A cycle-by-cycle vector table tells apart the undervoltage trip that is masked during soft-start from the one that latches after it. It also separates the self-releasing soft-crowbar from a latch, and checks that a latched fault masks overcurrent and overvoltage and is cleared by the enable.

// File: rtl/fault_sup_pkg.sv
package fault_sup_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMED   = 2'd1,
    ST_TRIPPED = 2'd2
  } supState_t;

  // Strobes from the control to the window timer datapath
  typedef struct packed {
    logic load;
    logic advance;
    logic clear;
  } timerCmd_t;
endpackage

// File: rtl/sup_window_timer.sv
module sup_window_timer
  import fault_sup_pkg::*;
#(
  parameter int WIN_LO = 8,
  parameter int WIN_HI = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  timerCmd_t cmd,
  output logic      inWindow,
  output logic      windowLast
);
  localparam int CNT_W = $clog2(WIN_HI + 1);
  localparam logic [CNT_W-1:0] LO_VAL = CNT_W'(WIN_LO);
  localparam logic [CNT_W-1:0] HI_VAL = CNT_W'(WIN_HI);

  logic [CNT_W-1:0] cycleCnt;

  // cycleCnt holds n during cycle k+n, where k is the arming cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cycleCnt <= '0;
    else if (cmd.clear)   cycleCnt <= '0;
    else if (cmd.load)    cycleCnt <= CNT_W'(1);
    else if (cmd.advance) cycleCnt <= cycleCnt + CNT_W'(1);
  end

  assign inWindow   = (cycleCnt >= LO_VAL) && (cycleCnt <= HI_VAL);
  assign windowLast = (cycleCnt == HI_VAL);
endmodule

// File: rtl/sup_control.sv
module sup_control
  import fault_sup_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      ocSample,
  input  logic      ssDone,
  input  logic      uvFlag,
  input  logic      ovFlag,
  input  logic      pgWindow,
  input  logic      inWindow,
  input  logic      windowLast,
  output timerCmd_t cmd,
  output logic      pulseEnd,
  output logic      hsOff,
  output logic      lsOn,
  output logic      faultLatched,
  output logic      pwrGood
);
  supState_t st, stNext;
  logic uvTrip, tripped, running;

  assign uvTrip = ssDone & uvFlag;   // undervoltage is masked during soft-start

  always_comb begin
    stNext = st;
    cmd    = '0;
    if (!enable) begin
      stNext    = ST_IDLE;
      cmd.clear = 1'b1;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (uvTrip) begin
            stNext    = ST_TRIPPED;
            cmd.clear = 1'b1;
          end else if (ocSample) begin
            stNext   = ST_ARMED;
            cmd.load = 1'b1;
          end
        end
        ST_ARMED: begin
          if (uvTrip || (ocSample && inWindow)) begin
            stNext    = ST_TRIPPED;
            cmd.clear = 1'b1;
          end else if (windowLast) begin
            stNext    = ST_IDLE;
            cmd.clear = 1'b1;
          end else begin
            cmd.advance = 1'b1;
          end
        end
        ST_TRIPPED: cmd.clear = 1'b1;
        default: begin
          stNext    = ST_IDLE;
          cmd.clear = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  assign tripped      = (st == ST_TRIPPED);
  assign running      = enable & ~tripped;
  assign faultLatched = tripped;
  assign pulseEnd     = running & ocSample;
  assign hsOff        = ~running | ovFlag;
  assign lsOn         = running & ovFlag;
  assign pwrGood      = running & ssDone & pgWindow;
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fault_sup_pkg::*;
#(
  parameter int WIN_LO = 8,
  parameter int WIN_HI = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic ocSample,
  input  logic ssDone,
  input  logic uvFlag,
  input  logic ovFlag,
  input  logic pgWindow,
  output logic pulseEnd,
  output logic hsOff,
  output logic lsOn,
  output logic faultLatched,
  output logic pwrGood
);
  timerCmd_t timerCmd;
  logic inWindow, windowLast;

  sup_window_timer #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_timer (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (timerCmd),
    .inWindow   (inWindow),
    .windowLast (windowLast)
  );

  sup_control u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .ocSample     (ocSample),
    .ssDone       (ssDone),
    .uvFlag       (uvFlag),
    .ovFlag       (ovFlag),
    .pgWindow     (pgWindow),
    .inWindow     (inWindow),
    .windowLast   (windowLast),
    .cmd          (timerCmd),
    .pulseEnd     (pulseEnd),
    .hsOff        (hsOff),
    .lsOn         (lsOn),
    .faultLatched (faultLatched),
    .pwrGood      (pwrGood)
  );
endmodule

// File: rtl/fault_sup_checker.sv
module fault_sup_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic ssDone,
  input logic uvFlag,
  input logic ovFlag,
  input logic pulseEnd,
  input logic hsOff,
  input logic lsOn,
  input logic faultLatched,
  input logic pwrGood
);
  AST_LS_ONLY_WITH_HS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    lsOn |-> hsOff);                                                    // R5
  AST_NO_PG_BEFORE_SS: assert property (@(posedge clk) disable iff (!rstN)
    !ssDone |-> !pwrGood);                                              // R6
  AST_UV_TRIPS: assert property (@(posedge clk) disable iff (!rstN)
    (enable && ssDone && uvFlag) |=> faultLatched);                     // R4
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (faultLatched && enable) |=> faultLatched);                         // R7
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !faultLatched);                                         // R7
  AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched |-> (hsOff && !lsOn && !pulseEnd && !pwrGood));        // R7
  AST_OV_NO_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !faultLatched && ovFlag && !uvFlag && !pulseEnd) |=> !faultLatched); // R5
endmodule

bind fault_supervisor fault_sup_checker u_fault_sup_checker (
  .clk          (clk),
  .rstN         (rstN),
  .enable       (enable),
  .ssDone       (ssDone),
  .uvFlag       (uvFlag),
  .ovFlag       (ovFlag),
  .pulseEnd     (pulseEnd),
  .hsOff        (hsOff),
  .lsOn         (lsOn),
  .faultLatched (faultLatched),
  .pwrGood      (pwrGood)
);

// File: tb/test_fault_supervisor.sv
`timescale 1ns/1ps
module test_fault_supervisor;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, ocSample = 1'b0, ssDone = 1'b0;
  logic uvFlag = 1'b0, ovFlag = 1'b0, pgWindow = 1'b0;
  logic pulseEnd, hsOff, lsOn, faultLatched, pwrGood;
  int   nRun = 0, nFail = 0;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  fault_supervisor i_fault_supervisor (
    .clk(clk), .rstN(rstN), .enable(enable), .ocSample(ocSample),
    .ssDone(ssDone), .uvFlag(uvFlag), .ovFlag(ovFlag), .pgWindow(pgWindow),
    .pulseEnd(pulseEnd), .hsOff(hsOff), .lsOn(lsOn),
    .faultLatched(faultLatched), .pwrGood(pwrGood)
  );

  // Inputs [10:5] = enable, ocSample, ssDone, uvFlag, ovFlag, pgWindow
  // Expected [4:0] = pulseEnd, hsOff, lsOn, faultLatched, pwrGood (same cycle)
  // Covers R1, R4, R5, R6, R7
  localparam int NVEC = 13;
  localparam logic [10:0] VEC [NVEC] = '{
    11'b000000_01000,  // disabled
    11'b100100_00000,  // R4 uv masked in soft-start
    11'b100001_00000,  // R6 no pwrGood before ssDone
    11'b101001_00001,  // R6 pwrGood
    11'b101010_01100,  // R5 crowbar
    11'b101010_01100,  // R5 crowbar held
    11'b101001_00001,  // R5 released, no latch
    11'b101100_00000,  // R4 uv after soft-start
    11'b101001_01010,  // R4 latched
    11'b111011_01010,  // R7 oc and ov masked while latched
    11'b000000_01010,  // R7 enable low, latch still visible
    11'b101001_00001,  // R7 cleared
    11'b111001_10001   // R1 pulse terminate
  };

  task automatic chk(input logic act, input logic exp, input string tag);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; enable = 1'b0; ocSample = 1'b0; ssDone = 1'b0;
    uvFlag = 1'b0; ovFlag = 1'b0; pgWindow = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    enable = 1'b1; ssDone = 1'b1; pgWindow = 1'b1;
  endtask

  // Overcurrent at cycles t0, t1, t2 (negative = unused); latch checked after the last
  task automatic ocSeq(input int t0, input int t1, input int t2,
                       input logic expLatch, input string tag);
    int last = (t2 > t1) ? t2 : t1;
    doReset();
    for (int c = 0; c <= last; c++) begin
      ocSample = (c == t0) || (c == t1) || (c == t2);
      #1;
      if (ocSample) chk(pulseEnd, 1'b1, {tag, " pulseEnd (R1)"});
      @(negedge clk);
    end
    ocSample = 1'b0;
    #1;
    chk(faultLatched, expLatch, tag);
  endtask

  initial begin
    // R8 reset state
    #2;
    chk(faultLatched, 1'b0, "R8 faultLatched in reset");
    chk(hsOff, 1'b1, "R8 hsOff in reset");
    chk(lsOn, 1'b0, "R8 lsOn in reset");
    chk(pulseEnd, 1'b0, "R8 pulseEnd in reset");
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk(faultLatched, 1'b0, "R8 faultLatched after reset");
    chk(hsOff, 1'b1, "R8 hsOff after reset");

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {enable, ocSample, ssDone, uvFlag, ovFlag, pgWindow} = VEC[i][10:5];
      #1;
      nRun++;
      if ({pulseEnd, hsOff, lsOn, faultLatched, pwrGood} !== VEC[i][4:0]) begin
        nFail++;
        $display("FAIL vector row %0d (R1 R4 R5 R6 R7) actual=%b expected=%b",
                 i, {pulseEnd, hsOff, lsOn, faultLatched, pwrGood}, VEC[i][4:0]);
      end
    end

    // Window edges
    ocSeq(0, 7, -1, 1'b0, "R3 second oc at +7");
    ocSeq(0, 8, -1, 1'b1, "R2 second oc at +8");
    ocSeq(0, 16, -1, 1'b1, "R2 second oc at +16");
    ocSeq(0, 17, -1, 1'b0, "R3 second oc at +17 rearms");
    ocSeq(0, 3, 10, 1'b1, "R3 early oc does not restart timer");
    ocSeq(0, 3, 19, 1'b0, "R3 window from first oc only");
    ocSeq(0, 17, 25, 1'b1, "R3 rearmed window trips");

    // R7 latch clears only via enable
    @(negedge clk);
    ocSample = 1'b1; ovFlag = 1'b1;
    #1;
    chk(pulseEnd, 1'b0, "R7 pulseEnd masked");
    chk(lsOn, 1'b0, "R7 lsOn masked");
    @(negedge clk);
    ocSample = 1'b0; ovFlag = 1'b0; enable = 1'b0;
    @(negedge clk);
    #1;
    chk(faultLatched, 1'b0, "R7 cleared by enable low");
    enable = 1'b1;
    @(negedge clk);
    #1;
    chk(pwrGood, 1'b1, "R6 pwrGood after clear");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule